// File: doc/BRIEF.md
# Filtered Interrupt Combiner

This block takes several asynchronous, active-low interrupt request lines, one for each downstream bus segment, and merges them into one request toward the host. Each line first passes through a synchronising flop chain. A per-line stability filter then rejects short pulses. A pulse that asserts a line and a pulse that briefly releases it each have their own rejection length, counted in system-clock cycles. The merged output asks for the shared pin to be pulled low whenever at least one filtered line is asserted. It is an active-high pull-down enable that models an open-drain driver.

Nothing is held. The merged request and the per-line state track the filtered inputs continuously, so a request goes away as soon as its source line returns high and stays high past the filter. Monitoring works on every line at all times, whatever bus segment is currently routed. For the register read path, a one-cycle capture strobe from the serial read logic copies the filtered per-line state into a status vector. The vector then holds until the next strobe. The neighbouring read logic places status bit n at bit n+4 of the byte it returns.

There is no data stream in this block. The capture strobe and all outputs are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `irq_combiner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_drive_low` is 0 and `status` is all zeros. Every filtered line comes out of reset deasserted.
- R2: `irq_drive_low` is 1 exactly when one or more filtered lines are asserted (low). Each line acts alone, and no line is masked by any selection.
- R3: With SYNC_STAGES = 2, a line held low from clock edge k is asserted in the filtered state after edge k+1+LOW_REJ. A low pulse seen at fewer than LOW_REJ consecutive edges never reaches the filtered state or `irq_drive_low`.
- R4: A line released high from edge k is deasserted in the filtered state after edge k+1+HIGH_REJ. A high pulse seen at fewer than HIGH_REJ consecutive edges is ignored.
- R5: When `capture` is 1 at an edge, `status` takes the filtered state after that edge. Bit n is 1 when line n is asserted low (bit 0 = line 0).
- R6: When `capture` is 0 at an edge, `status` keeps its value.
- R7: No request is latched. Once all lines are filtered high, `irq_drive_low` returns to 0 and the next capture reads all zeros.
- R8: Several lines asserted together are each reported in their own `status` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n_in | input | NUM_IN | Asynchronous active-low request lines, bit n = line n |
| capture | input | 1 | One-cycle strobe that copies the filtered state into `status` |
| irq_drive_low | output | 1 | Pull-down enable for the shared active-low request pin |
| status | output | NUM_IN | Snapshot of the filtered state, 1 = line asserted |

## Verification
The stimulus covers each line asserted alone, which separates a wrong bit position or a per-line mask from a correct merge. It also covers two lines asserted together and then released one at a time, which shows whether reporting is independent and whether the status holds between strobes. Pulses one cycle shorter than each rejection length, and pulses exactly equal to it, pin down the filter boundaries for both polarities. The assert and release latencies are checked to the exact edge. A long run of random line levels and random strobes, compared every cycle against a behavioural model, exercises overlapping filter restarts that directed cases would miss.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  // Counter width able to hold the larger of two rejection lengths.
  function automatic int rej_cnt_width(input int lo_len, input int hi_len);
    int top;
    top = (lo_len > hi_len) ? lo_len : hi_len;
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

  // Filter polarity: which kind of change a line is waiting to confirm.
  typedef enum logic {
    WAIT_FALL = 1'b0,
    WAIT_RISE = 1'b1
  } filt_dir_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain_q [STAGES];

  // Idle level of an active-low request is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irq_glitch_filter.sv
module irq_glitch_filter
  import irq_comb_pkg::*;
#(
  parameter int LOW_REJ  = 4,
  parameter int HIGH_REJ = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,   // synchronised, active low
  output logic level_out   // filtered, active low
);

  localparam int CW = rej_cnt_width(LOW_REJ, HIGH_REJ);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_REJ - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_REJ - 1);

  logic          state_q;
  logic [CW-1:0] run_q;
  filt_dir_e     dir;
  logic [CW-1:0] last_cnt;

  // Currently high: waiting for a fall; currently low: waiting for a rise.
  assign dir      = state_q ? WAIT_FALL : WAIT_RISE;
  assign last_cnt = (dir == WAIT_FALL) ? LOW_LAST : HIGH_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b1;
      run_q   <= '0;
    end else if (level_in == state_q) begin
      run_q <= '0;                       // disagreement ended, restart
    end else if (run_q == last_cnt) begin
      state_q <= level_in;               // new level held long enough
      run_q   <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level_out = state_q;

endmodule

// File: rtl/irq_status_snap.sv
module irq_status_snap #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [WIDTH-1:0] filt_n,
  output logic [WIDTH-1:0] snap
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (capture) snap <= ~filt_n;   // 1 = request present
  end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NUM_IN      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_REJ     = 4,
  parameter int HIGH_REJ    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_n_in,
  input  logic              capture,
  output logic              irq_drive_low,
  output logic [NUM_IN-1:0] status
);

  logic [NUM_IN-1:0] sync_q;
  logic [NUM_IN-1:0] filt_q;

  irq_sync #(
    .WIDTH (NUM_IN),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(irq_n_in),
    .sync_out(sync_q)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_filt
    irq_glitch_filter #(
      .LOW_REJ (LOW_REJ),
      .HIGH_REJ(HIGH_REJ)
    ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (sync_q[g]),
      .level_out(filt_q[g])
    );
  end

  // Wired-AND of active-low lines: pull low if any line is low.
  assign irq_drive_low = ~(&filt_q);

  irq_status_snap #(
    .WIDTH(NUM_IN)
  ) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .filt_n (filt_q),
    .snap   (status)
  );

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NUM_IN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              capture,
  input logic              irq_drive_low,
  input logic [NUM_IN-1:0] status,
  input logic [NUM_IN-1:0] filt,
  input logic [NUM_IN-1:0] sync
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (status == '0 && !irq_drive_low));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(status));

  // R5
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (status == ~$past(filt)));

  for (genvar g = 0; g < NUM_IN; g++) begin : g_line
    // R3
    fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filt[g]) |-> !$past(sync[g]));
    // R4
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filt[g]) |-> $past(sync[g]));
  end

endmodule

bind irq_combiner irq_combiner_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .capture      (capture),
  .irq_drive_low(irq_drive_low),
  .status       (status),
  .filt         (filt_q),
  .sync         (sync_q)
);

// File: tb/irq_combiner_test.sv
module irq_combiner_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int LR = 3;
  localparam int HR = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         capture = 1'b0;
  logic [N-1:0] irq_n = '1;
  logic         drv;
  logic [N-1:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_en = 0;
  bit seen_drv = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_combiner #(
    .NUM_IN(N), .SYNC_STAGES(2), .LOW_REJ(LR), .HIGH_REJ(HR)
  ) uut (
    .clk(clk), .rst_n(rst_n), .irq_n_in(irq_n), .capture(capture),
    .irq_drive_low(drv), .status(status)
  );

  // Behavioural reference: a two-deep delay queue and run-length integers.
  logic [N-1:0] dq[$];
  logic [N-1:0] m_filt, m_status;
  int           m_run[N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq = '{'1, '1};
      m_filt = '1; m_status = '0;
      for (int i = 0; i < N; i++) m_run[i] = 0;
    end else begin
      logic [N-1:0] seen;
      if (capture) m_status = ~m_filt;
      seen = dq[0];
      for (int i = 0; i < N; i++) begin
        if (seen[i] == m_filt[i]) m_run[i] = 0;
        else begin
          m_run[i]++;
          if (m_run[i] >= (m_filt[i] ? LR : HR)) begin
            m_filt[i] = seen[i];
            m_run[i] = 0;
          end
        end
      end
      dq.push_back(irq_n);
      void'(dq.pop_front());
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (drv) seen_drv = 1;
    if (cmp_en && rst_n) begin
      check("R2 model drive", 32'(drv), 32'(m_filt != '1));
      check("R5 model status", 32'(status), 32'(m_status));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    capture = 1'b1; cyc(1); capture = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    done = 1;
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    check("R1 reset drive", 32'(drv), 0);
    check("R1 reset status", 32'(status), 0);
    rst_n = 1'b1;
    cyc(1);
    check("R1 first cycle drive", 32'(drv), 0);
    cmp_en = 1;
    cyc(3);
    strobe();
    check("R7 idle capture", 32'(status), 0);

    // R3 assert latency: low from the next edge k, visible after edge k+1+LR.
    irq_n[0] = 1'b0;
    cyc(LR + 1);
    check("R3 before latency", 32'(drv), 0);
    cyc(1);
    check("R3 at latency", 32'(drv), 1);
    strobe();
    check("R5 single line", 32'(status), 32'h1);

    // R4 high glitch one short of HR is ignored.
    irq_n[0] = 1'b1; cyc(HR - 1); irq_n[0] = 1'b0;
    cyc(HR + 4);
    check("R4 high glitch kept asserted", 32'(drv), 1);

    // R4 release latency.
    irq_n[0] = 1'b1;
    cyc(HR + 1);
    check("R4 before release", 32'(drv), 1);
    cyc(1);
    check("R4 at release", 32'(drv), 0);
    strobe();
    check("R7 cleared after release", 32'(status), 0);

    // R8 two lines together, R6 hold without strobe.
    irq_n = 4'b0101;
    cyc(LR + 3);
    strobe();
    check("R8 two lines", 32'(status), 32'hA);
    irq_n[1] = 1'b1;
    cyc(HR + 4);
    check("R6 status held", 32'(status), 32'hA);
    check("R2 remaining line drives", 32'(drv), 1);
    strobe();
    check("R8 one line left", 32'(status), 32'h8);
    irq_n = '1;
    cyc(HR + 4);
    check("R7 all released", 32'(drv), 0);

    // R3 low glitch boundaries.
    seen_drv = 0;
    irq_n[2] = 1'b0; cyc(LR - 1); irq_n[2] = 1'b1;
    cyc(LR + 6);
    check("R3 short low pulse ignored", 32'(seen_drv), 0);
    seen_drv = 0;
    irq_n[2] = 1'b0; cyc(LR); irq_n[2] = 1'b1;
    cyc(LR + 6);
    check("R3 exact low pulse accepted", 32'(seen_drv), 1);
    cyc(HR + 4);

    // R2 each line alone.
    for (int ch = 0; ch < N; ch++) begin
      irq_n = '1; irq_n[ch] = 1'b0;
      cyc(LR + 3);
      check("R2 line alone drives", 32'(drv), 1);
      strobe();
      check("R5 line position", 32'(status), 32'(1 << ch));
      irq_n = '1;
      cyc(HR + 3);
      check("R7 line alone releases", 32'(drv), 0);
    end

    // Random levels and strobes, compared to the model every cycle.
    for (int t = 0; t < 3000; t++) begin
      if ($urandom_range(0, 5) == 0) irq_n = N'($urandom);
      capture = ($urandom_range(0, 7) == 0);
      cyc(1);
    end
    capture = 1'b0;
    cyc(2);
    finish_run();
  end

endmodule